// File: doc/BRIEF.md
# Legacy IDE PIO Timing Controller

This block is the IDE channel engine of a bridge that turns legacy I/O port accesses into ATA PIO cycles on a parallel drive bus. A 16-bit timing control word sets up the block through a simple register port. The word switches the IDE function on or off, picks the primary or secondary legacy address set and interrupt line, and holds one control nibble per drive. It also holds the parameters of a single shared fast timing bank.

The host side issues one-cycle requests that carry an I/O address, a write flag and write data. When the address falls in the active channel's command block or its control register, the block runs one drive cycle. It drives the chip selects and the register address, and asserts the read or write strobe for a width set by the selected drive's timing. If enabled, it stretches the strobe while the drive holds IORDY low. It then pulses done, returning read data for a read, and keeps the bus quiet for the recovery time. Only after that does it accept the next request. The drive that receives the timing is the one last selected through the drive/head register.

Top module: `legacy_ide_pio_engine`

## Requirements
- R1: With bit 15 of the timing word clear, no address is claimed, no strobe is asserted and no done pulse occurs. The host ready output stays high.
- R2: With bit 14 clear, the block claims I/O addresses 0x1F0..0x1F7 (chip select 0 low, register address = address bits 2:0) and 0x3F6 (chip select 1 low, register address 6). With bit 14 set, it claims 0x170..0x177 and 0x376 instead. Any other address is ignored.
- R3: The interrupt line output reads 14 for the primary set and 15 for the secondary set while the function is enabled, and 0 when it is disabled.
- R4: A drive whose fast-timing bit is clear gets a strobe of 12 clocks and a recovery of 8 clocks, whatever the bank fields hold.
- R5: A drive on the fast bank gets a strobe of 5, 4, 3 or 2 clocks for bits 13:12 equal to 0, 1, 2 or 3.
- R6: A drive on the fast bank gets 4, 3, 2 or 1 recovery clocks after done for bits 9:8 equal to 0, 1, 2 or 3. Ready returns when recovery ends.
- R7: For a fast-bank drive with its IORDY bit set, IORDY low at the sample point lengthens the strobe by one clock per low clock, up to 64 extra clocks. IORDY has no effect for other drives.
- R8: Per-drive nibbles sit at bits 3:0 (drive 0) and 7:4 (drive 1). Within a nibble, bit 0 selects the fast bank, bit 1 enables IORDY and bit 2 enables prefetch. The drive is chosen by bit 4 of the last write to command offset 6 and is drive 0 after reset. That write still uses the previous drive's timing.
- R9: A read of command offset 0 returns all 16 data bits. Other registers return the low byte with the upper byte zero. A write drives the data bus only during the strobe, with the upper byte zero except at offset 0.
- R10: The timing word, reserved bits included, reads back exactly as last written and is zero after reset.
- R11: A request made while a cycle or its recovery is under way is ignored. It causes no cycle, no done pulse and no drive select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Timing word write enable |
| cfg_wr_data | input | 16 | Timing word write value |
| cfg_rd_data | output | 16 | Timing word readback |
| host_req | input | 1 | One-cycle I/O request |
| host_wr | input | 1 | Request is a write |
| host_addr | input | 16 | Legacy I/O address |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | Block idle, request can be taken |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with done |
| irq_num | output | 4 | Interrupt line of the channel (0 when disabled) |
| ide_cs0_n | output | 1 | Command block chip select |
| ide_cs1_n | output | 1 | Control block chip select |
| ide_da | output | 3 | Drive register address |
| ide_dior_n | output | 1 | Read strobe |
| ide_diow_n | output | 1 | Write strobe |
| ide_iordy | input | 1 | Drive ready |
| ide_dd_in | input | 16 | Data from drive |
| ide_dd_out | output | 16 | Data to drive |
| ide_dd_oe | output | 1 | Data bus drive enable |

## Verification
A wrong latched drive select or wrong latched timing shows on the very next cycle as a strobe width or recovery length off by whole clocks. The bench measures these lengths at the strobe pins and at ready, so such faults show within one access. A decode fault shows as a missing or extra strobe and done pulse on the access that hits the wrong address. A fault in the IORDY extension shows as a strobe that is too long or too short by the number of clocks IORDY was held low, capped at the timeout.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
   localparam int TIM_W         = 16;
   localparam int DATA_W        = 16;
   localparam int ADDR_W        = 16;
   localparam int DRIVES        = 2;
   localparam int NIB_W         = 4;
   localparam int BIT_ENABLE    = 15;
   localparam int BIT_SECONDARY = 14;
   localparam int ISP_LSB       = 12;
   localparam int REC_LSB       = 8;
   localparam int NIB_FAST      = 0;
   localparam int NIB_IORDY     = 1;
   localparam int FAST_ISP_MAX  = 5;
   localparam int FAST_REC_MAX  = 4;
   localparam int DRVSEL_BIT    = 4;
   localparam logic [2:0] DRVHEAD_OFS = 3'd6;
   localparam logic [2:0] CTL_DA      = 3'd6;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ACTIVE  = 2'd1,
      ST_RECOVER = 2'd2
   } cyc_state_e;
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
   import ide_pio_pkg::*;
(
   input  logic              enable,
   input  logic              secondary,
   input  logic [ADDR_W-1:0] addr,
   output logic              cmd_hit,
   output logic              ctl_hit,
   output logic [2:0]        da,
   output logic              wide,
   output logic [3:0]        irq_num
);
   localparam logic [ADDR_W-1:0] PRI_CMD = 16'h01F0;
   localparam logic [ADDR_W-1:0] SEC_CMD = 16'h0170;
   localparam logic [ADDR_W-1:0] PRI_CTL = 16'h03F6;
   localparam logic [ADDR_W-1:0] SEC_CTL = 16'h0376;

   logic [ADDR_W-1:0] cmd_base, ctl_addr;

   always_comb begin
      cmd_base = secondary ? SEC_CMD : PRI_CMD;
      ctl_addr = secondary ? SEC_CTL : PRI_CTL;
      cmd_hit  = enable && (addr[ADDR_W-1:3] == cmd_base[ADDR_W-1:3]);
      ctl_hit  = enable && (addr == ctl_addr);
      da       = cmd_hit ? addr[2:0] : CTL_DA;
      wide     = cmd_hit && (addr[2:0] == 3'd0);
      irq_num  = !enable ? 4'd0 : (secondary ? 4'd15 : 4'd14);
   end
endmodule

// File: rtl/ide_timing_select.sv
module ide_timing_select
   import ide_pio_pkg::*;
#(
   parameter int CNT_W          = 4,
   parameter int COMPAT_ACTIVE  = 12,
   parameter int COMPAT_RECOVER = 8
) (
   input  logic [DRIVES-1:0] fast_bits,
   input  logic [DRIVES-1:0] iordy_bits,
   input  logic [1:0]        isp_code,
   input  logic [1:0]        rec_code,
   input  logic              drv_sel,
   output logic [CNT_W-1:0]  act_len,
   output logic [CNT_W-1:0]  rec_len,
   output logic              wait_en
);
   logic [CNT_W-1:0] bank_act, bank_rec;

   always_comb begin
      bank_act = CNT_W'(FAST_ISP_MAX - int'(isp_code));
      bank_rec = CNT_W'(FAST_REC_MAX - int'(rec_code));
      if (fast_bits[drv_sel]) begin
         act_len = bank_act;
         rec_len = bank_rec;
      end else begin
         act_len = CNT_W'(COMPAT_ACTIVE);
         rec_len = CNT_W'(COMPAT_RECOVER);
      end
      wait_en = fast_bits[drv_sel] & iordy_bits[drv_sel];
   end
endmodule

// File: rtl/ide_cycle_fsm.sv
module ide_cycle_fsm
   import ide_pio_pkg::*;
#(
   parameter int CNT_W         = 4,
   parameter int IORDY_TIMEOUT = 64,
   parameter int WAIT_W        = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_write,
   input  logic              sel_cmd,
   input  logic [2:0]        da_in,
   input  logic              wide,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  act_len,
   input  logic [CNT_W-1:0]  rec_len,
   input  logic              wait_en,
   input  logic              iordy,
   input  logic [DATA_W-1:0] dd_in,
   output logic              ready,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              cs0_n,
   output logic              cs1_n,
   output logic [2:0]        da,
   output logic              dior_n,
   output logic              diow_n,
   output logic [DATA_W-1:0] dd_out,
   output logic              dd_oe
);
   localparam int HALF = DATA_W / 2;

   cyc_state_e        state;
   logic [CNT_W-1:0]  cnt, act_q, rec_q;
   logic [WAIT_W-1:0] wcnt;
   logic              wr_q, cmd_q, wide_q, wait_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         wcnt    <= '0;
         act_q   <= '0;
         rec_q   <= '0;
         wr_q    <= 1'b0;
         cmd_q   <= 1'b0;
         wide_q  <= 1'b0;
         wait_q  <= 1'b0;
         wdata_q <= '0;
         da      <= '0;
         done    <= 1'b0;
         rdata   <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               state   <= ST_ACTIVE;
               cnt     <= CNT_W'(1);
               wcnt    <= '0;
               act_q   <= act_len;
               rec_q   <= rec_len;
               wr_q    <= is_write;
               cmd_q   <= sel_cmd;
               wide_q  <= wide;
               wait_q  <= wait_en;
               wdata_q <= wdata;
               da      <= da_in;
            end
            ST_ACTIVE: begin
               if (cnt != act_q) begin
                  cnt <= cnt + CNT_W'(1);
               end else if (wait_q && !iordy && (wcnt != WAIT_W'(IORDY_TIMEOUT))) begin
                  wcnt <= wcnt + WAIT_W'(1);
               end else begin
                  state <= ST_RECOVER;
                  cnt   <= CNT_W'(1);
                  done  <= 1'b1;
                  if (!wr_q)
                     rdata <= wide_q ? dd_in : {{HALF{1'b0}}, dd_in[HALF-1:0]};
               end
            end
            ST_RECOVER: begin
               if (cnt == rec_q) state <= ST_IDLE;
               else              cnt   <= cnt + CNT_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ready  = (state == ST_IDLE);
      cs0_n  = !((state != ST_IDLE) && cmd_q);
      cs1_n  = !((state != ST_IDLE) && !cmd_q);
      dior_n = !((state == ST_ACTIVE) && !wr_q);
      diow_n = !((state == ST_ACTIVE) && wr_q);
      dd_oe  = (state == ST_ACTIVE) && wr_q;
      dd_out = wide_q ? wdata_q : {{HALF{1'b0}}, wdata_q[HALF-1:0]};
   end
endmodule

// File: rtl/legacy_ide_pio_engine.sv
module legacy_ide_pio_engine
   import ide_pio_pkg::*;
#(
   parameter int COMPAT_ACTIVE  = 12,
   parameter int COMPAT_RECOVER = 8,
   parameter int IORDY_TIMEOUT  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [TIM_W-1:0]  cfg_wr_data,
   output logic [TIM_W-1:0]  cfg_rd_data,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ready,
   output logic              host_done,
   output logic [DATA_W-1:0] host_rdata,
   output logic [3:0]        irq_num,
   output logic              ide_cs0_n,
   output logic              ide_cs1_n,
   output logic [2:0]        ide_da,
   output logic              ide_dior_n,
   output logic              ide_diow_n,
   input  logic              ide_iordy,
   input  logic [DATA_W-1:0] ide_dd_in,
   output logic [DATA_W-1:0] ide_dd_out,
   output logic              ide_dd_oe
);
   localparam int MAX_A   = (COMPAT_ACTIVE > FAST_ISP_MAX) ? COMPAT_ACTIVE : FAST_ISP_MAX;
   localparam int MAX_R   = (COMPAT_RECOVER > FAST_REC_MAX) ? COMPAT_RECOVER : FAST_REC_MAX;
   localparam int MAX_LEN = (MAX_A > MAX_R) ? MAX_A : MAX_R;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);
   localparam int WAIT_W  = $clog2(IORDY_TIMEOUT + 1);

   if (COMPAT_ACTIVE < 1 || COMPAT_RECOVER < 1) begin : g_bad_compat
      $error("compatible timing lengths must be at least one clock");
   end
   if (IORDY_TIMEOUT < 1) begin : g_bad_timeout
      $error("IORDY timeout must be at least one clock");
   end

   logic [TIM_W-1:0]  tim_q;
   logic              drv_sel_q;
   logic [DRIVES-1:0] fast_bits, iordy_bits;
   logic              cmd_hit, ctl_hit, wide, start, wait_en;
   logic [2:0]        dec_da;
   logic [CNT_W-1:0]  act_len, rec_len;

   for (genvar d = 0; d < DRIVES; d++) begin : g_drv
      assign fast_bits[d]  = tim_q[d*NIB_W + NIB_FAST];
      assign iordy_bits[d] = tim_q[d*NIB_W + NIB_IORDY];
   end

   assign start       = host_req && host_ready && (cmd_hit || ctl_hit);
   assign cfg_rd_data = tim_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tim_q     <= '0;
         drv_sel_q <= 1'b0;
      end else begin
         if (cfg_wr_en) tim_q <= cfg_wr_data;
         if (start && host_wr && cmd_hit && (host_addr[2:0] == DRVHEAD_OFS))
            drv_sel_q <= host_wdata[DRVSEL_BIT];
      end
   end

   ide_addr_decode dec_i (
      .enable    (tim_q[BIT_ENABLE]),
      .secondary (tim_q[BIT_SECONDARY]),
      .addr      (host_addr),
      .cmd_hit   (cmd_hit),
      .ctl_hit   (ctl_hit),
      .da        (dec_da),
      .wide      (wide),
      .irq_num   (irq_num)
   );

   ide_timing_select #(
      .CNT_W          (CNT_W),
      .COMPAT_ACTIVE  (COMPAT_ACTIVE),
      .COMPAT_RECOVER (COMPAT_RECOVER)
   ) tsel_i (
      .fast_bits  (fast_bits),
      .iordy_bits (iordy_bits),
      .isp_code   (tim_q[ISP_LSB +: 2]),
      .rec_code   (tim_q[REC_LSB +: 2]),
      .drv_sel    (drv_sel_q),
      .act_len    (act_len),
      .rec_len    (rec_len),
      .wait_en    (wait_en)
   );

   ide_cycle_fsm #(
      .CNT_W         (CNT_W),
      .IORDY_TIMEOUT (IORDY_TIMEOUT),
      .WAIT_W        (WAIT_W)
   ) fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_write (host_wr),
      .sel_cmd  (cmd_hit),
      .da_in    (dec_da),
      .wide     (wide),
      .wdata    (host_wdata),
      .act_len  (act_len),
      .rec_len  (rec_len),
      .wait_en  (wait_en),
      .iordy    (ide_iordy),
      .dd_in    (ide_dd_in),
      .ready    (host_ready),
      .done     (host_done),
      .rdata    (host_rdata),
      .cs0_n    (ide_cs0_n),
      .cs1_n    (ide_cs1_n),
      .da       (ide_da),
      .dior_n   (ide_dior_n),
      .diow_n   (ide_diow_n),
      .dd_out   (ide_dd_out),
      .dd_oe    (ide_dd_oe)
   );
endmodule

// File: rtl/ide_pio_checker.sv
module ide_pio_checker #(
   parameter int MAX_STROBE = 76
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_wr_en,
   input logic [15:0] cfg_wr_data,
   input logic [15:0] cfg_rd_data,
   input logic        host_ready,
   input logic        host_done,
   input logic [3:0]  irq_num,
   input logic        ide_cs0_n,
   input logic        ide_cs1_n,
   input logic        ide_dior_n,
   input logic        ide_diow_n,
   input logic        ide_dd_oe
);
   logic [7:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                         run_q <= '0;
      else if (!ide_dior_n || !ide_diow_n) run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
      else                                run_q <= '0;
   end

   // R1: idle and disabled stays idle
   p_disabled_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ready && !cfg_rd_data[15]) |=> host_ready);

   p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!ide_dior_n, !ide_diow_n}));

   p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!ide_cs0_n, !ide_cs1_n}));

   p_irq_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_data[15] |-> (irq_num == (cfg_rd_data[14] ? 4'd15 : 4'd14)));

   p_done_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |-> $past(!ide_dior_n || !ide_diow_n));

   p_strobe_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= 8'(MAX_STROBE));

   p_write_drives_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ide_diow_n |-> ide_dd_oe);

   p_cfg_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en |=> (cfg_rd_data == $past(cfg_wr_data)));

   p_done_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |-> !host_ready);
endmodule

bind legacy_ide_pio_engine ide_pio_checker chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wr_en   (cfg_wr_en),
   .cfg_wr_data (cfg_wr_data),
   .cfg_rd_data (cfg_rd_data),
   .host_ready  (host_ready),
   .host_done   (host_done),
   .irq_num     (irq_num),
   .ide_cs0_n   (ide_cs0_n),
   .ide_cs1_n   (ide_cs1_n),
   .ide_dior_n  (ide_dior_n),
   .ide_diow_n  (ide_diow_n),
   .ide_dd_oe   (ide_dd_oe)
);

// File: tb/legacy_ide_pio_engine_tb_top.sv
`timescale 1ns/1ps
module legacy_ide_pio_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [15:0] cfg_wr_data = '0;
   logic [15:0] cfg_rd_data;
   logic        host_req = 1'b0, host_wr = 1'b0;
   logic [15:0] host_addr = '0, host_wdata = '0;
   logic        host_ready, host_done;
   logic [15:0] host_rdata;
   logic [3:0]  irq_num;
   logic        ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, ide_dd_oe;
   logic [2:0]  ide_da;
   logic        ide_iordy = 1'b1;
   logic [15:0] ide_dd_in = 16'hBEEF;
   logic [15:0] ide_dd_out;

   int checks = 0, fails = 0, done_cnt = 0;
   bit finished = 0;
   bit drv = 0;

   always #2.5 clk = ~clk;

   legacy_ide_pio_engine dut_i (.*);

   always @(posedge clk) if (rst_n && host_done) done_cnt++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   function automatic int exp_act(input logic [15:0] c, input bit d);
      return c[4*d] ? 5 - int'(c[13:12]) : 12;
   endfunction
   function automatic int exp_rec(input logic [15:0] c, input bit d);
      return c[4*d] ? 4 - int'(c[9:8]) : 8;
   endfunction
   function automatic int exp_wait(input logic [15:0] c, input bit d, input int k);
      if (c[4*d] && c[4*d+1]) return (k > 64) ? 64 : k;
      return 0;
   endfunction

   task automatic set_cfg(input logic [15:0] v);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_data = v;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   // Runs one request; measures strobe and recovery lengths at the pins.
   task automatic access(input logic [15:0] addr, input bit wr, input logic [15:0] wd,
                         input int base_n, input int k,
                         output int a_len, output int r_len, output bit got_done,
                         output logic [15:0] rd, output bit cs0, output bit cs1,
                         output logic [2:0] da_s, output logic [15:0] dout_s, output bit oe_s);
      int guard = 0;
      while (!host_ready && guard < 500) begin guard++; @(negedge clk); end
      host_req = 1'b1; host_addr = addr; host_wr = wr; host_wdata = wd; ide_iordy = 1'b1;
      @(negedge clk);
      host_req = 1'b0;
      a_len = 0; cs0 = 1; cs1 = 1; da_s = '0; dout_s = '0; oe_s = 0;
      while ((!ide_dior_n || !ide_diow_n) && a_len < 500) begin
         if (a_len == 0) begin
            cs0 = ide_cs0_n; cs1 = ide_cs1_n; da_s = ide_da; dout_s = ide_dd_out; oe_s = ide_dd_oe;
         end
         a_len++;
         ide_iordy = !(a_len >= base_n && a_len < base_n + k);
         @(negedge clk);
      end
      got_done = host_done; rd = host_rdata; ide_iordy = 1'b1;
      r_len = 0;
      while (!host_ready && r_len < 500) begin r_len++; @(negedge clk); end
   endtask

   task automatic timed(input string req, input logic [15:0] c, input logic [15:0] addr,
                        input bit wr, input logic [15:0] wd, input int k);
      int a, r; bit dn, c0, c1, oe; logic [15:0] rd, dout; logic [2:0] da;
      int en = exp_act(c, drv);
      access(addr, wr, wd, en, k, a, r, dn, rd, c0, c1, da, dout, oe);
      eq({req, " strobe"}, a, en + exp_wait(c, drv, k));
      eq({req, " recovery"}, r, exp_rec(c, drv));
      if (wr && addr[2:0] == 3'd6 && addr[15:4] == 12'h01F) drv = wd[4];
   endtask

   initial begin
      int a, r; bit dn, c0, c1, oe; logic [15:0] rd, dout, c; logic [2:0] da;
      int d0;
      void'($urandom(32'h1DE5EED));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R10, R1)
      eq("R10 reset word", cfg_rd_data, 0);
      eq("R1 reset ready", host_ready, 1);
      eq("R1 reset strobes", {ide_dior_n, ide_diow_n, ide_cs0_n, ide_cs1_n}, 4'hF);
      eq("R3 irq disabled", irq_num, 0);

      // R10: reserved bits read back
      set_cfg(16'h0C11);
      eq("R10 readback", cfg_rd_data, 16'h0C11);

      // R1: disabled, no cycle
      d0 = done_cnt;
      access(16'h01F0, 0, 0, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R1 no strobe", a, 0);
      repeat (3) @(negedge clk);
      eq("R1 no done", done_cnt - d0, 0);

      // primary, compatible timing
      set_cfg(16'h8000);
      eq("R3 irq primary", irq_num, 14);
      ide_dd_in = 16'hBEEF;
      access(16'h01F0, 0, 0, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R4 compat strobe", a, 12);
      eq("R4 compat recovery", r, 8);
      eq("R9 wide read", rd, 16'hBEEF);
      eq("R2 cmd select", {c0, c1, da}, {2'b01, 3'd0});
      eq("R4 done seen", dn, 1);
      access(16'h01F2, 0, 0, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R9 narrow read", rd, 16'h00EF);
      eq("R2 da offset", da, 2);
      access(16'h01F3, 1, 16'h1234, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R9 narrow write", dout, 16'h0034);
      eq("R9 write oe", oe, 1);
      access(16'h01F0, 1, 16'hA5C3, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R9 wide write", dout, 16'hA5C3);
      access(16'h03F6, 0, 0, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R2 ctl select", {c0, c1, da}, {2'b10, 3'd6});
      d0 = done_cnt;
      access(16'h0170, 0, 0, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R2 other set ignored", a, 0);
      access(16'h03F7, 0, 0, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R2 near ctl ignored", a, 0);
      repeat (2) @(negedge clk);
      eq("R2 no done on miss", done_cnt - d0, 0);

      // secondary
      set_cfg(16'hC000);
      eq("R3 irq secondary", irq_num, 15);
      access(16'h0177, 0, 0, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R2 secondary cmd", {a, 8'(c0), 8'(da)}, {32'd12, 8'd0, 8'd7});
      access(16'h0376, 0, 0, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R2 secondary ctl", {8'(c1), 8'(da)}, {8'd0, 8'd6});
      access(16'h01F0, 0, 0, 12, 0, a, r, dn, rd, c0, c1, da, dout, oe);
      eq("R2 primary ignored", a, 0);

      // fast bank, all codes (R5, R6)
      drv = 0;
      for (int code = 0; code < 4; code++) begin
         c = 16'h8001 | 16'(code << 12) | 16'(((3 - code) & 3) << 8);
         set_cfg(c);
         timed("R5 R6 bank codes", c, 16'h01F1, 0, 0, 0);
      end
      // R4: bank fields ignored without fast bit
      c = 16'hB300; set_cfg(c);
      timed("R4 fields ignored", c, 16'h01F1, 0, 0, 0);

      // R7 IORDY
      c = 16'h8203; set_cfg(c);
      timed("R7 short wait", c, 16'h01F1, 0, 0, 3);
      timed("R7 timeout", c, 16'h01F1, 0, 0, 100);
      c = 16'h8202; set_cfg(c);
      timed("R7 compat ignores iordy", c, 16'h01F1, 0, 0, 5);
      c = 16'h8201; set_cfg(c);
      timed("R7 disabled ignores iordy", c, 16'h01F1, 0, 0, 5);

      // R8 drive select
      c = 16'hB010; set_cfg(c);
      timed("R8 drive0 compat", c, 16'h01F1, 0, 0, 0);
      timed("R8 select write", c, 16'h01F6, 1, 16'h0010, 0);
      timed("R8 drive1 fast", c, 16'h01F1, 0, 0, 0);
      timed("R8 deselect write", c, 16'h01F6, 1, 16'h00EF, 0);
      timed("R8 drive0 again", c, 16'h01F1, 0, 0, 0);

      // R11 busy request ignored
      d0 = done_cnt;
      @(negedge clk);
      host_req = 1; host_addr = 16'h01F0; host_wr = 1; host_wdata = 16'h0;
      @(negedge clk);
      host_req = 0;
      @(negedge clk);
      host_req = 1; host_addr = 16'h01F6; host_wdata = 16'h0010;
      @(negedge clk);
      host_req = 0;
      while (!host_ready) @(negedge clk);
      repeat (2) @(negedge clk);
      eq("R11 single done", done_cnt - d0, 1);
      timed("R11 select unchanged", c, 16'h01F1, 0, 0, 0);

      // constrained random
      for (int i = 0; i < 60; i++) begin
         c = 16'($urandom) | 16'h8000;
         c[14] = 1'b0;
         set_cfg(c);
         if ($urandom_range(0, 3) == 0)
            timed("R8 random select", c, 16'h01F6, 1, 16'($urandom), 0);
         timed("R5 R6 R7 random", c, 16'h01F0 | 16'($urandom_range(0, 7)),
               1'($urandom), 16'($urandom), $urandom_range(0, 70));
         eq("R10 random readback", cfg_rd_data, c);
      end

      if (!finished) begin
         finished = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule